// File: doc/BRIEF.md
# Multiplexed Prescaler Counter Bank

The block holds eight independent programmable dividers that run from the event clock. Each channel has a 32-bit prescaler N. Its output is a clock-like waveform with a period of N event-clock cycles: it is high for the first floor(N/2) cycles of each period and low for the rest. A per-channel polarity bit can invert that waveform. Downstream logic uses the eight outputs as trigger sources, distributed-bus sources or sequencer triggers.

Software-style writes set the prescaler and the polarity of one channel at a time. A new prescaler value waits in a pending register and is adopted at the next period boundary. A common synchronous phase-reset input restarts every channel at the first cycle of a period, loads its pending value at once, and so puts all eight outputs in phase.

Top module: `mux_prescaler_bank`

## Requirements
- R1: While rst_ni is low, and after its release until a channel is programmed, every bit of tick_o is 0. All prescalers and polarities reset to 0.
- R2: For an active prescaler N with 2 <= N, the raw waveform repeats every N cycles. It is high for floor(N/2) cycles from the period start and low for N - floor(N/2) cycles. This gives 1/1 for N=2, 1 high and 2 low for N=3, and 2 high and 3 low for N=5.
- R3: A channel whose prescaler is 0 or 1 holds its raw waveform low, so its tick_o bit equals its polarity bit.
- R4: tick_o[c] is the raw waveform XOR the channel's polarity bit (1 = inverted). A polarity write takes effect on the clock edge that performs the write.
- R5: A prescaler written while a channel is running takes effect only at the end of the current period. The cycles left in that period follow the old value.
- R6: When sync_i is high at a clock edge, every channel restarts at cycle 0 of a period using its pending prescaler. Outputs of channels with N >= 2 are then high (raw) in the cycle that follows.
- R7: A write with wr_en_i high changes only the channel selected by wr_ch_i (binary channel index 0..7). All other channels are unaffected.
- R8: A channel idling at prescaler 0 or 1 adopts a newly written valid prescaler on the next edge after the write, without needing sync_i.
- R9: The period counter never reaches or passes the active prescaler. The maximum value 2^32-1 runs without overflow and gives a high phase of 2^31-1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Event clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Common phase reset, synchronous, active high |
| wr_en_i | input | 1 | Write strobe for one channel's settings |
| wr_ch_i | input | 3 | Channel index of the write |
| wr_div_i | input | 32 | Prescaler value to write |
| wr_pol_i | input | 1 | Polarity to write (1 = inverted) |
| tick_o | output | 8 | Divided outputs, one bit per channel |

## Verification
The main test loads all eight channels with the consecutive prescalers 2 through 9 at once. Mixing even and odd divisors side by side separates a correct floor(N/2) high phase from rounding up, and separates it from a symmetric split. It also exposes cross-talk between channels. Further patterns use prescalers 0 and 1 under both polarities, a mid-period prescaler change that must not cut the running period short, and an unaligned run that is then realigned by the phase reset. The largest prescaler shows that the high phase does not wrap early.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  localparam int unsigned MIN_DIV = 2;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mpb_wr_decode.sv
module mpb_wr_decode #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_ch_i,
  output logic [NUM_CH-1:0] wr_sel_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign wr_sel_o[g] = wr_en_i && (wr_ch_i == IDX_W'(g));
  end
endmodule

// File: rtl/mpb_channel.sv
module mpb_channel
  import mpb_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] div_i,
  input  logic             pol_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_o,
  output logic [CNT_W-1:0] pend_o
);
  logic [CNT_W-1:0] cnt_q, act_q, pend_q;
  logic             pol_q;
  logic             act_ok, last, raw;

  assign act_ok = act_q >= CNT_W'(MIN_DIV);
  assign last   = cnt_q == act_q - CNT_W'(1);
  // high for floor(N/2) cycles at period start
  assign raw    = act_ok && (cnt_q < (act_q >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      act_q  <= '0;
      pend_q <= '0;
      pol_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        pend_q <= div_i;
        pol_q  <= pol_i;
      end
      if (sync_i || !act_ok || last) begin
        cnt_q <= '0;
        act_q <= pend_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign tick_o = raw ^ pol_q;
  assign cnt_o  = cnt_q;
  assign act_o  = act_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/mux_prescaler_bank.sv
module mux_prescaler_bank
  import mpb_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned IDX_W = idx_width(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_ch_i,
  input  logic [CNT_W-1:0]  wr_div_i,
  input  logic              wr_pol_i,
  output logic [NUM_CH-1:0] tick_o
);
  logic [NUM_CH-1:0]            wr_sel;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt, ch_act, ch_pend;

  mpb_wr_decode #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_dec (
    .wr_en_i (wr_en_i),
    .wr_ch_i (wr_ch_i),
    .wr_sel_o(wr_sel)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    mpb_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sync_i(sync_i),
      .wr_i  (wr_sel[g]),
      .div_i (wr_div_i),
      .pol_i (wr_pol_i),
      .tick_o(tick_o[g]),
      .cnt_o (ch_cnt[g]),
      .act_o (ch_act[g]),
      .pend_o(ch_pend[g])
    );
  end
endmodule

// File: rtl/mpb_checker.sv
module mpb_checker #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CNT_W  = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        sync_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] act_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] pend_i
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R9: counter stays inside the active period
    a_r9_cnt_below_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i[g] >= CNT_W'(2)) |-> (cnt_i[g] < act_i[g]));

    // R2: counter advances by one inside a period
    a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sync_i && act_i[g] >= CNT_W'(2) && cnt_i[g] != act_i[g] - CNT_W'(1))
      |=> (cnt_i[g] == $past(cnt_i[g]) + CNT_W'(1)));

    // R5: active prescaler is held until the period ends
    a_r5_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sync_i && act_i[g] >= CNT_W'(2) && cnt_i[g] != act_i[g] - CNT_W'(1))
      |=> $stable(act_i[g]));

    // R6: phase reset restarts the period with the pending value
    a_r6_sync_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_i |=> (cnt_i[g] == '0 && act_i[g] == $past(pend_i[g])));

    // R8: idle channel picks up the pending value on the next edge
    a_r8_idle_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i[g] < CNT_W'(2)) |=> (act_i[g] == $past(pend_i[g]) && cnt_i[g] == '0));
  end
endmodule

bind mux_prescaler_bank mpb_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .sync_i(sync_i),
  .cnt_i (ch_cnt),
  .act_i (ch_act),
  .pend_i(ch_pend)
);

// File: tb/mux_prescaler_bank_tb.sv
module mux_prescaler_bank_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_ch_i = '0;
  logic [31:0] wr_div_i = '0;
  logic        wr_pol_i = 1'b0;
  logic [7:0]  tick_o;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_cnt[8], m_act[8], m_pend[8];
  logic        m_pol[8];

  always #4 clk_i = ~clk_i;

  mux_prescaler_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .wr_en_i(wr_en_i),
    .wr_ch_i(wr_ch_i), .wr_div_i(wr_div_i), .wr_pol_i(wr_pol_i), .tick_o(tick_o)
  );

  // Model built from R2..R8
  task automatic model_step();
    for (int c = 0; c < 8; c++) begin
      if (sync_i || m_act[c] < 2 || m_cnt[c] == m_act[c] - 1) begin
        m_cnt[c] = 0;
        m_act[c] = m_pend[c];
      end else begin
        m_cnt[c] = m_cnt[c] + 1;
      end
      if (wr_en_i && wr_ch_i == 3'(c)) begin
        m_pend[c] = wr_div_i;
        m_pol[c]  = wr_pol_i;
      end
    end
  endtask

  task automatic compare(string tag);
    for (int c = 0; c < 8; c++) begin
      logic exp;
      exp = ((m_act[c] >= 2) && (m_cnt[c] < (m_act[c] >> 1))) ^ m_pol[c];
      checks++;
      if (tick_o[c] !== exp) begin
        errors++;
        $display("FAIL %s ch%0d tick actual=%b expected=%b", tag, c, tick_o[c], exp);
      end
    end
  endtask

  task automatic cycle(string tag);
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  task automatic wr(int ch, logic [31:0] div, logic pol, string tag);
    wr_en_i = 1'b1; wr_ch_i = 3'(ch); wr_div_i = div; wr_pol_i = pol;
    cycle(tag);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_sync(string tag);
    sync_i = 1'b1;
    cycle(tag);
    sync_i = 1'b0;
  endtask

  task automatic t_reset();
    for (int c = 0; c < 8; c++) begin
      m_cnt[c] = 0; m_act[c] = 0; m_pend[c] = 0; m_pol[c] = 0;
    end
    repeat (3) @(negedge clk_i);
    checks++;
    if (tick_o !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset tick actual=%h expected=00", tick_o);
    end
    rst_ni = 1'b1;
    run(4, "R1");
  endtask

  task automatic t_duty();
    for (int c = 0; c < 8; c++) wr(c, 32'(c + 2), 1'b0, "R7");
    run(3, "R2");
    pulse_sync("R6");
    // explicit duty count for N=3 (ch1) and N=5 (ch3) over one period from sync
    begin
      int hi3 = 0, hi5 = 0;
      if (tick_o[1]) hi3++;
      if (tick_o[3]) hi5++;
      for (int i = 1; i < 15; i++) begin
        cycle("R2");
        if (i < 3 && tick_o[1]) hi3++;
        if (i < 5 && tick_o[3]) hi5++;
      end
      checks++;
      if (hi3 != 1) begin errors++; $display("FAIL R2 N=3 high cycles actual=%0d expected=1", hi3); end
      checks++;
      if (hi5 != 2) begin errors++; $display("FAIL R2 N=5 high cycles actual=%0d expected=2", hi5); end
    end
    run(40, "R2");
  endtask

  task automatic t_pol();
    wr(1, 32'd3, 1'b1, "R4");
    wr(4, 32'd6, 1'b1, "R4");
    run(30, "R4");
    wr(4, 32'd6, 1'b0, "R4");
    run(12, "R4");
  endtask

  task automatic t_idle();
    wr(0, 32'd0, 1'b0, "R3");
    wr(5, 32'd1, 1'b1, "R3");
    run(20, "R3");
    checks++;
    if (tick_o[0] !== 1'b0 || tick_o[5] !== 1'b1) begin
      errors++;
      $display("FAIL R3 idle ch0/ch5 actual=%b%b expected=01", tick_o[0], tick_o[5]);
    end
    wr(0, 32'd4, 1'b0, "R8");
    run(16, "R8");
  endtask

  task automatic t_change();
    pulse_sync("R6");
    run(1, "R5");
    wr(2, 32'd7, 1'b0, "R5");
    run(30, "R5");
    wr(6, 32'd2, 1'b1, "R5");
    run(20, "R5");
  endtask

  task automatic t_phase();
    wr(3, 32'd9, 1'b0, "R6");
    run(5, "R6");
    pulse_sync("R6");
    checks++;
    // every valid channel starts high (raw), so tick equals inverted polarity
    if (tick_o[2] !== 1'b1 || tick_o[3] !== 1'b1 || tick_o[6] !== 1'b0) begin
      errors++;
      $display("FAIL R6 aligned start ch2/3/6 actual=%b%b%b expected=110",
               tick_o[2], tick_o[3], tick_o[6]);
    end
    run(40, "R6");
  endtask

  task automatic t_large();
    wr(7, 32'hFFFF_FFFF, 1'b0, "R9");
    pulse_sync("R9");
    run(200, "R9");
    checks++;
    if (tick_o[7] !== 1'b1) begin
      errors++;
      $display("FAIL R9 max prescaler high phase actual=%b expected=1", tick_o[7]);
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_duty();
    t_pol();
    t_idle();
    t_change();
    t_phase();
    t_large();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule